// File: doc/BRIEF.md
# Serial EEPROM Station-Address Autoloader

This block fetches the first eight 16-bit words of a four-wire serial EEPROM, once, after every hardware reset. Each word is requested with a nine-bit command: a three-bit read opcode followed by a six-bit word address. The block clocks the reply in bit by bit. All eight words go into a 16-byte address-PROM array. The first three words also go into three 16-bit station-address registers, which together hold the 48-bit station address. A single read pass fills both destinations, so the EEPROM is walked only once.

While the load runs, `busy_o` is high. When the last word has been stored, `done_o` is set and stays set until the next hardware reset. The host then has byte-wide access to the PROM array. Reads are combinational. Writes overwrite a byte and have no effect on the station-address registers. Host writes issued during the load are dropped. No software-initiated reload exists: only a hardware reset (`rst_n` low) starts a new pass.

Top module: `eeprom_autoload`

## Requirements
- R1: While `rst_n` is low: `busy_o`=1, `done_o`=0, `ee_cs_o`=0 and `ee_sk_o`=0. Every PROM byte and every station-address register reads 0.
- R2: Each frame drives nine command bits on `ee_mosi_o`, MSB first: opcode binary 110, then the 6-bit word address. Data out changes only while the serial clock is low. The 16 reply bits are then sampled MSB first on the next 16 rising serial-clock edges.
- R3: Exactly eight frames follow each hardware reset, for word addresses 0,1,...,7 in that order. Chip select stays low once `done_o` is set.
- R4: The serial clock has a period of `CLK_DIV` system clocks. It is high for `CLK_DIV/2` of them, and it is low whenever chip select is low.
- R5: Between two frames, chip select stays low for at least `CLK_DIV` system clocks.
- R6: PROM byte 2k holds bits 7:0 of EEPROM word k, and byte 2k+1 holds bits 15:8, for k = 0..7.
- R7: Station register k (`sta_wordk_o`, k = 0..2) equals EEPROM word k. Byte 2k is in bits 7:0 and byte 2k+1 is in bits 15:8.
- R8: `busy_o` falls and `done_o` rises on the same edge that stores word 7. This happens within 8*(26*`CLK_DIV`+2) clocks of reset release. `done_o` then holds until the next reset.
- R9: `host_rdata_o` shows the PROM byte selected by `host_addr_i` in the same cycle.
- R10: Once `done_o` is set, a host write replaces the addressed byte from the next clock. The other bytes and all three station registers do not change.
- R11: A host write while `busy_o` is high changes no PROM byte.
- R12: Asserting `rst_n` again repeats the whole load, so the EEPROM values replace any bytes the host has overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, asynchronous active-low, released synchronously inside |
| ee_cs_o | output | 1 | EEPROM chip select, active high |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_mosi_o | output | 1 | Command bits to the EEPROM |
| ee_miso_i | input | 1 | Reply bits from the EEPROM |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load finished |
| host_we_i | input | 1 | Host byte write strobe |
| host_addr_i | input | 4 | Host byte address into the PROM array |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | PROM byte at `host_addr_i` |
| sta_word0_o | output | 16 | Station address bytes 1:0 |
| sta_word1_o | output | 16 | Station address bytes 3:2 |
| sta_word2_o | output | 16 | Station address bytes 5:4 |

## Verification
A host read is due in the same cycle as its address. A host write is due one clock later. The bench drives on the falling edge and compares on the next falling edge, so exactly one rising edge lies between stimulus and result. The serial interface is checked by an EEPROM model that samples the pins on every falling system-clock edge. It counts serial-clock high time, period and chip-select gaps in system cycles, and it shifts each reply bit out just after a serial-clock fall, so the bit is stable at the rise that samples it. The full load is given its computed deadline of 8*(26*`CLK_DIV`+2) cycles. The stored bytes and station words are checked only after `done_o` is seen, because they are all written no later than the edge that raises it.

// File: rtl/eal_pkg.sv
package eal_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = 16;
  localparam int NUM_WORDS  = 8;
  localparam int PROM_BYTES = 2 * NUM_WORDS;
  localparam int STA_REGS   = 3;
  localparam int EADDR_W    = 6;
  localparam int OPC_W      = 3;
  localparam int CMD_W      = OPC_W + EADDR_W;
  localparam int FRAME_BITS = CMD_W + WORD_W;
  localparam int IDX_W      = $clog2(NUM_WORDS);
  localparam int HADDR_W    = $clog2(PROM_BYTES);
  localparam logic [OPC_W-1:0] RD_OPC = 3'b110;

  typedef enum logic [1:0] {RD_IDLE, RD_SHIFT, RD_GAP} rd_state_e;
  typedef enum logic {SEQ_LOAD, SEQ_DONE} seq_state_e;
endpackage

// File: rtl/eal_sclk_gen.sv
module eal_sclk_gen #(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic sk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = $clog2(CLK_DIV);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    if (!en_i || cnt_q == CNT_W'(CLK_DIV - 1)) cnt_n = '0;
    else                                       cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign sk_o   = en_i && (cnt_q >= CNT_W'(HALF));
  assign rise_o = en_i && (cnt_q == CNT_W'(HALF - 1));
  assign fall_o = en_i && (cnt_q == CNT_W'(CLK_DIV - 1));
endmodule

// File: rtl/eal_word_reader.sv
module eal_word_reader
  import eal_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [EADDR_W-1:0] addr_i,
  output logic               idle_o,
  output logic               valid_o,
  output logic [WORD_W-1:0]  word_o,
  output logic               cs_o,
  output logic               sk_o,
  output logic               mosi_o,
  input  logic               miso_i
);
  localparam int BIT_W = $clog2(FRAME_BITS + 1);
  localparam int GAP_W = $clog2(CLK_DIV);

  rd_state_e          st_q, st_n;
  logic [CMD_W-1:0]   cmd_q, cmd_n;
  logic [WORD_W-1:0]  din_q, din_n;
  logic [BIT_W-1:0]   bit_q, bit_n;
  logic [GAP_W-1:0]   gap_q, gap_n;
  logic               vld_q, vld_n;
  logic               rise, fall;

  eal_sclk_gen #(.CLK_DIV(CLK_DIV)) sclk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (st_q == RD_SHIFT),
    .sk_o  (sk_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  always_comb begin
    st_n  = st_q;
    cmd_n = cmd_q;
    din_n = din_q;
    bit_n = bit_q;
    gap_n = gap_q;
    vld_n = 1'b0;
    unique case (st_q)
      RD_IDLE: if (start_i) begin
        st_n  = RD_SHIFT;
        cmd_n = {RD_OPC, addr_i};
        bit_n = '0;
      end
      RD_SHIFT: begin
        if (rise) begin
          bit_n = bit_q + 1'b1;
          if (bit_q >= BIT_W'(CMD_W)) din_n = {din_q[WORD_W-2:0], miso_i};
        end
        if (fall) begin
          cmd_n = {cmd_q[CMD_W-2:0], 1'b0};
          if (bit_q == BIT_W'(FRAME_BITS)) begin
            st_n  = RD_GAP;
            gap_n = '0;
            vld_n = 1'b1;
          end
        end
      end
      RD_GAP: begin
        gap_n = gap_q + 1'b1;
        if (gap_q == GAP_W'(CLK_DIV - 1)) st_n = RD_IDLE;
      end
      default: st_n = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RD_IDLE;
      cmd_q <= '0;
      din_q <= '0;
      bit_q <= '0;
      gap_q <= '0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cmd_q <= cmd_n;
      din_q <= din_n;
      bit_q <= bit_n;
      gap_q <= gap_n;
      vld_q <= vld_n;
    end
  end

  assign idle_o  = (st_q == RD_IDLE);
  assign valid_o = vld_q;
  assign word_o  = din_q;
  assign cs_o    = (st_q == RD_SHIFT);
  assign mosi_o  = (st_q == RD_SHIFT) && cmd_q[CMD_W-1];
endmodule

// File: rtl/eal_prom_store.sv
module eal_prom_store
  import eal_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ld_we_i,
  input  logic [IDX_W-1:0]                 ld_idx_i,
  input  logic [WORD_W-1:0]                ld_word_i,
  input  logic                             host_we_i,
  input  logic [HADDR_W-1:0]               host_addr_i,
  input  logic [BYTE_W-1:0]                host_wdata_i,
  output logic [BYTE_W-1:0]                host_rdata_o,
  output logic [STA_REGS-1:0][WORD_W-1:0]  sta_o
);
  logic [PROM_BYTES*BYTE_W-1:0] flat;

  for (genvar b = 0; b < PROM_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] byte_q, byte_n;
    always_comb begin
      byte_n = byte_q;
      if (ld_we_i && ld_idx_i == IDX_W'(b / 2))
        byte_n = ld_word_i[BYTE_W*(b % 2) +: BYTE_W];
      else if (host_we_i && host_addr_i == HADDR_W'(b))
        byte_n = host_wdata_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_n;
    end
    assign flat[b*BYTE_W +: BYTE_W] = byte_q;
  end

  for (genvar k = 0; k < STA_REGS; k++) begin : g_sta
    logic [WORD_W-1:0] sta_q;
    logic              sta_en;
    assign sta_en = ld_we_i && ld_idx_i == IDX_W'(k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sta_q <= '0;
      else if (sta_en) sta_q <= ld_word_i;
    end
    assign sta_o[k] = sta_q;
  end

  assign host_rdata_o = flat[host_addr_i*BYTE_W +: BYTE_W];
endmodule

// File: rtl/eeprom_autoload.sv
module eeprom_autoload
  import eal_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        ee_cs_o,
  output logic        ee_sk_o,
  output logic        ee_mosi_o,
  input  logic        ee_miso_i,
  output logic        busy_o,
  output logic        done_o,
  input  logic        host_we_i,
  input  logic [3:0]  host_addr_i,
  input  logic [7:0]  host_wdata_i,
  output logic [7:0]  host_rdata_o,
  output logic [15:0] sta_word0_o,
  output logic [15:0] sta_word1_o,
  output logic [15:0] sta_word2_o
);
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  seq_state_e         seq_q, seq_n;
  logic [IDX_W-1:0]   idx_q, idx_n;
  logic               rd_idle, rd_valid, rd_start;
  logic [WORD_W-1:0]  rd_word;
  logic [STA_REGS-1:0][WORD_W-1:0] sta;

  assign rd_start = (seq_q == SEQ_LOAD) && rd_idle;

  always_comb begin
    seq_n = seq_q;
    idx_n = idx_q;
    if (seq_q == SEQ_LOAD && rd_valid) begin
      idx_n = idx_q + 1'b1;
      if (idx_q == IDX_W'(NUM_WORDS - 1)) seq_n = SEQ_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      seq_q <= SEQ_LOAD;
      idx_q <= '0;
    end else begin
      seq_q <= seq_n;
      idx_q <= idx_n;
    end
  end

  eal_word_reader #(.CLK_DIV(CLK_DIV)) rdr_i (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .start_i(rd_start),
    .addr_i ({{(EADDR_W-IDX_W){1'b0}}, idx_q}),
    .idle_o (rd_idle),
    .valid_o(rd_valid),
    .word_o (rd_word),
    .cs_o   (ee_cs_o),
    .sk_o   (ee_sk_o),
    .mosi_o (ee_mosi_o),
    .miso_i (ee_miso_i)
  );

  eal_prom_store store_i (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .ld_we_i     (rd_valid && seq_q == SEQ_LOAD),
    .ld_idx_i    (idx_q),
    .ld_word_i   (rd_word),
    .host_we_i   (host_we_i && seq_q == SEQ_DONE),
    .host_addr_i (host_addr_i),
    .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o),
    .sta_o       (sta)
  );

  assign busy_o      = (seq_q == SEQ_LOAD);
  assign done_o      = (seq_q == SEQ_DONE);
  assign sta_word0_o = sta[0];
  assign sta_word1_o = sta[1];
  assign sta_word2_o = sta[2];
endmodule

// File: rtl/eal_checker.sv
module eal_checker #(
  parameter int CLK_DIV = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs,
  input logic        sk,
  input logic        mosi,
  input logic        busy,
  input logic        done,
  input logic [47:0] sta
);
  localparam int LW = $clog2(CLK_DIV) + 2;

  logic [LW-1:0] low_cnt;
  logic          cs_prev, seen_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt    <= '0;
      cs_prev    <= 1'b0;
      seen_frame <= 1'b0;
    end else begin
      cs_prev <= cs;
      if (cs) begin
        low_cnt    <= '0;
        seen_frame <= 1'b1;
      end else if (low_cnt != {LW{1'b1}}) begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  assert_sk_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !sk);

  assert_cs_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !cs_prev && seen_frame) |-> (low_cnt >= LW'(CLK_DIV)));

  assert_mosi_held_at_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && $rose(sk)) |-> $stable(mosi));

  assert_quiet_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cs);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !busy));

  assert_sta_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(sta));
endmodule

bind eeprom_autoload eal_checker #(.CLK_DIV(CLK_DIV)) chk_i (
  .clk (clk),
  .rst_n(rst_q_n),
  .cs  (ee_cs_o),
  .sk  (ee_sk_o),
  .mosi(ee_mosi_o),
  .busy(busy_o),
  .done(done_o),
  .sta ({sta_word2_o, sta_word1_o, sta_word0_o})
);

// File: tb/eeprom_autoload_tb_top.sv
`timescale 1ns/1ps
module eeprom_autoload_tb_top;
  localparam int CLK_DIV  = 8;
  localparam int HALF     = CLK_DIV / 2;
  localparam int DEADLINE = 8 * (26 * CLK_DIV + 2);
  localparam int NVEC     = 12;

  // {we, addr, wdata, expected read-back}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 4'd0,  8'h00, 8'h3C},
    {1'b0, 4'd1,  8'h00, 8'h19},
    {1'b0, 4'd5,  8'h00, 8'h85},
    {1'b0, 4'd6,  8'h00, 8'hE2},
    {1'b0, 4'd9,  8'h00, 8'h71},
    {1'b0, 4'd15, 8'h00, 8'h17},
    {1'b1, 4'd15, 8'h5A, 8'h5A},
    {1'b1, 4'd0,  8'hC3, 8'hC3},
    {1'b0, 4'd1,  8'h00, 8'h19},
    {1'b0, 4'd14, 8'h00, 8'h3A},
    {1'b1, 4'd4,  8'h00, 8'h00},
    {1'b0, 4'd12, 8'h00, 8'h80}
  };

  logic clk, rst_n, miso, host_we;
  logic [3:0]  host_addr;
  logic [7:0]  host_wdata, host_rdata;
  logic cs, sk, mosi, busy, done;
  logic [15:0] sta0, sta1, sta2;

  int nchk, nfail, cycles;
  int frames, bad_cmd, sk_bad, gap_bad;

  eeprom_autoload #(.CLK_DIV(CLK_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ee_cs_o(cs), .ee_sk_o(sk), .ee_mosi_o(mosi), .ee_miso_i(miso),
    .busy_o(busy), .done_o(done),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata),
    .sta_word0_o(sta0), .sta_word1_o(sta1), .sta_word2_o(sta2)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] img_byte(int b);
    return 8'h3C ^ 8'(b * 37);
  endfunction

  function automatic logic [15:0] img_word(int a);
    return {img_byte(2 * a + 1), img_byte(2 * a)};
  endfunction

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // EEPROM model, sampled on falling system-clock edges
  logic cs_p, sk_p;
  logic [8:0] cmd;
  int nbit, since, hi, lowcnt;
  bit seen_rise;
  initial begin
    cs_p = 0; sk_p = 0; cmd = '0; nbit = 0; since = 0; hi = 0; lowcnt = 0; seen_rise = 0;
    frames = 0; bad_cmd = 0; sk_bad = 0; gap_bad = 0; miso = 1'b0;
  end
  always @(negedge clk) begin
    logic [15:0] w;
    if (cs && !cs_p) begin
      if (frames > 0 && lowcnt < CLK_DIV) gap_bad++;
      nbit = 0; cmd = '0; seen_rise = 0; since = 0;
    end
    if (cs) lowcnt = 0; else lowcnt++;
    if (!cs && sk) sk_bad++;
    if (sk && !sk_p) begin
      if (seen_rise && since != CLK_DIV) sk_bad++;
      since = 0; hi = 0; seen_rise = 1;
      if (cs) begin
        if (nbit < 9) cmd = {cmd[7:0], mosi};
        nbit++;
      end
    end
    if (!sk && sk_p) begin
      if (hi != HALF) sk_bad++;
      if (cs && nbit >= 9 && nbit < 25) begin
        w = img_word(int'(cmd[5:0]));
        miso = w[15 - (nbit - 9)];
      end
    end
    if (sk) hi++;
    since++;
    if (!cs && cs_p) begin
      if (cmd[8:6] !== 3'b110 || int'(cmd[5:0]) != (frames % 8) || nbit != 25) bad_cmd++;
      frames++;
    end
    cs_p = cs; sk_p = sk;
  end

  always @(posedge clk) cycles++;

  initial begin
    cycles = 0;
    wait (cycles > 100000);
    nfail++; nchk++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  task automatic wait_done(string req);
    int n = 0;
    while (!done && n < DEADLINE) begin @(negedge clk); n++; end
    chk(req, {47'b0, done}, 48'd1);
  endtask

  task automatic host_op(bit we, logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  initial begin
    nchk = 0; nfail = 0;
    host_we = 0; host_addr = 0; host_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {47'b0, busy}, 48'd1);
    chk("R1 done", {47'b0, done}, 48'd0);
    chk("R1 cs/sk", {46'b0, cs, sk}, 48'd0);
    chk("R1 station", {sta2, sta1, sta0}, 48'd0);
    chk("R1 prom", {40'b0, host_rdata}, 48'd0);
    rst_n = 1'b1;

    // R11: host writes during the load are dropped
    while (frames < 2) @(negedge clk);
    chk("R8 busy mid-load", {46'b0, busy, done}, 48'd2);
    host_op(1'b1, 4'd10, 8'hFF);
    host_op(1'b1, 4'd0, 8'h00);

    wait_done("R8 done by deadline");
    chk("R8 busy low", {47'b0, busy}, 48'd0);

    host_addr = 4'd10; @(negedge clk);
    chk("R11 byte10", {40'b0, host_rdata}, {40'b0, img_byte(10)});
    host_addr = 4'd0; @(negedge clk);
    chk("R11 byte0", {40'b0, host_rdata}, {40'b0, img_byte(0)});

    // R6 / R9: every byte, combinational read
    for (int b = 0; b < 16; b++) begin
      host_addr = 4'(b); #1;
      chk("R6 R9 byte", {40'b0, host_rdata}, {40'b0, img_byte(b)});
    end
    // R7
    chk("R7 station", {sta2, sta1, sta0}, {img_word(2), img_word(1), img_word(0)});

    // R3: no further frames
    repeat (600) @(negedge clk);
    chk("R3 frame count", 48'(frames), 48'd8);
    chk("R3 R2 frame content", 48'(bad_cmd), 48'd0);
    chk("R4 sclk shape", 48'(sk_bad), 48'd0);
    chk("R5 cs gap", 48'(gap_bad), 48'd0);

    // R9 / R10 table
    for (int i = 0; i < NVEC; i++) begin
      host_op(VEC[i][20], VEC[i][19:16], VEC[i][15:8]);
      chk(VEC[i][20] ? "R10 write" : "R9 read", {40'b0, host_rdata}, {40'b0, VEC[i][7:0]});
    end
    chk("R10 station untouched", {sta2, sta1, sta0}, {img_word(2), img_word(1), img_word(0)});

    // R12: reload on a new hardware reset
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 prom cleared", {40'b0, host_rdata}, 48'd0);
    rst_n = 1'b1;
    wait_done("R12 done");
    host_addr = 4'd0; @(negedge clk);
    chk("R12 byte0", {40'b0, host_rdata}, {40'b0, img_byte(0)});
    host_addr = 4'd15; @(negedge clk);
    chk("R12 byte15", {40'b0, host_rdata}, {40'b0, img_byte(15)});
    chk("R12 frames", 48'(frames), 48'd16);
    chk("R12 R2 frames", 48'(bad_cmd), 48'd0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule